// File: doc/BRIEF.md
# Serial Gain Word Receiver

This block is the digital control front end of a programmable-gain line driver. A host loads an 8-bit gain code over a three-wire port: an active-low load enable, a serial data line and a serial clock. While the enable is low, the bits enter a two-stage register. A bit is taken into a master stage on each rising serial clock edge and moved into the shifting slave stage on the following falling edge. When the enable goes high, the shifted word is committed to a held gain latch, and any further shifting is blocked.

All port pins are asynchronous to the system clock. They pass through a two-flop synchronizer, and the edges are detected in the system clock domain. The latched code is limited to the valid range 0..79, and a flag marks any write that had to be limited. The gain is also given in fixed point, at 0.7526 dB per code step. The transmit-enable and active-low sleep pins are decoded into three mode flags that are mutually exclusive.

Top module: `gain_serial_rx`

## Requirements
- R1: After reset, gain_code_o is 0, gain_db_o is 0, clamp_o is 0, idle_o is 1, and tx_on_o and sleep_o are 0.
- R2: The word is 8 bits long and arrives most significant bit first. The last 8 bits shifted before the rising edge of sen_ni form the committed word.
- R3: While sen_ni is low, and at any time other than a rising edge of sen_ni, gain_code_o, gain_db_o and clamp_o hold their values.
- R4: Serial clock edges that occur while sen_ni is high do not change the shift register. A later commit that has no clock edges in between re-delivers the previous word.
- R5: A rising sclk_i edge captures sdata_i into the master stage, and the falling edge moves that bit into the shift register. A change of sdata_i between the rise and the fall has no effect on that bit.
- R6: A committed word above 79 is latched as 79 with clamp_o=1. A committed word of 79 or below is latched unchanged with clamp_o=0. gain_code_o never exceeds 79.
- R7: gain_db_o equals gain_code_o × 7526, in units of 0.1 mdB, and is 20 bits wide.
- R8: sleep_ni=0 gives sleep_o=1, whatever tx_en_i is. Otherwise tx_en_i=1 gives tx_on_o=1, and tx_en_i=0 gives idle_o=1 (terminated, not transmitting). Exactly one of the three flags is high.
- R9: The gain outputs change on the third clk_i rising edge after the sen_ni rise. The mode flags change on the second clk_i rising edge after a pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sen_ni | input | 1 | Load enable, active low; rising edge commits |
| sdata_i | input | 1 | Serial data, MSB first |
| sclk_i | input | 1 | Serial clock |
| tx_en_i | input | 1 | Transmit enable, asynchronous |
| sleep_ni | input | 1 | Sleep request, active low, asynchronous |
| gain_code_o | output | 8 | Latched gain code, 0..79 |
| gain_db_o | output | 20 | Gain in 0.1 mdB units |
| clamp_o | output | 1 | Last commit was out of range and limited |
| tx_on_o | output | 1 | Transmitting |
| idle_o | output | 1 | Transmission off, output terminated |
| sleep_o | output | 1 | Sleep mode |

## Verification
Each pin goes through two synchronizer flops. The gain outputs then take one more register, so they are due on the third clk_i rise after sen_ni goes high, while the mode flags are due on the second rise. The bench drives every pin on a falling clk_i edge and samples on falling edges. It checks the old gain value two falling edges after the commit and the new value at the third, and it checks the mode flags at the second. Within each serial bit, the bench holds each serial level for four system cycles, which is long enough for every edge to pass the synchronizer before the next one arrives.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int unsigned CODE_W   = 8;
  localparam int unsigned MAX_CODE = 79;
  localparam int unsigned STEP_01M = 7526;  // 0.1 mdB per code step
  localparam int unsigned DB_W     = $clog2(MAX_CODE * STEP_01M + 1);

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_TX    = 2'd1,
    MODE_SLEEP = 2'd2
  } mode_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int unsigned    W       = 1,
  parameter int unsigned    STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/srx_shift.sv
module srx_shift #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sen_n_s_i,
  input  logic              sclk_s_i,
  input  logic              sdata_s_i,
  output logic [CODE_W-1:0] word_o
);
  logic              sclk_prev_q;
  logic              master_q;
  logic [CODE_W-1:0] slave_q;
  logic              rise, fall, load_ok;

  assign load_ok = ~sen_n_s_i;
  assign rise    = sclk_s_i & ~sclk_prev_q;
  assign fall    = ~sclk_s_i & sclk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b0;
      master_q    <= 1'b0;
      slave_q     <= '0;
    end else begin
      sclk_prev_q <= sclk_s_i;
      if (load_ok && rise) master_q <= sdata_s_i;
      if (load_ok && fall) slave_q  <= {slave_q[CODE_W-2:0], master_q};
    end
  end

  assign word_o = slave_q;

  // R4
  hold_when_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sen_n_s_i |=> $stable(slave_q));

  // R5
  master_only_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sclk_s_i && !sclk_prev_q) |=> $stable(master_q));
endmodule

// File: rtl/srx_latch.sv
module srx_latch #(
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned MAX_CODE = 79
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sen_n_s_i,
  input  logic [CODE_W-1:0] word_i,
  output logic [CODE_W-1:0] code_o,
  output logic              clamp_o
);
  localparam logic [CODE_W-1:0] MAX_V = CODE_W'(MAX_CODE);

  logic              sen_prev_q;
  logic [CODE_W-1:0] code_q;
  logic              clamp_q;
  logic              commit, over;

  assign commit = sen_n_s_i & ~sen_prev_q;
  assign over   = word_i > MAX_V;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sen_prev_q <= 1'b1;
      code_q     <= '0;
      clamp_q    <= 1'b0;
    end else begin
      sen_prev_q <= sen_n_s_i;
      if (commit) begin
        code_q  <= over ? MAX_V : word_i;
        clamp_q <= over;
      end
    end
  end

  assign code_o  = code_q;
  assign clamp_o = clamp_q;

  // R3
  latch_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sen_n_s_i |=> $stable(code_q) && $stable(clamp_q));

  // R6
  code_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_q <= MAX_V);

  // R6
  clamp_at_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clamp_q |-> code_q == MAX_V);
endmodule

// File: rtl/srx_mode.sv
module srx_mode
  import srx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_en_s_i,
  input  logic sleep_n_s_i,
  output logic tx_on_o,
  output logic idle_o,
  output logic sleep_o
);
  mode_e mode;

  always_comb begin
    if (!sleep_n_s_i)   mode = MODE_SLEEP;
    else if (tx_en_s_i) mode = MODE_TX;
    else                mode = MODE_IDLE;
  end

  assign tx_on_o = (mode == MODE_TX);
  assign idle_o  = (mode == MODE_IDLE);
  assign sleep_o = (mode == MODE_SLEEP);

  // R8
  one_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({tx_on_o, idle_o, sleep_o}) == 1);

  // R8
  sleep_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_n_s_i |-> sleep_o && !tx_on_o);
endmodule

// File: rtl/gain_serial_rx.sv
module gain_serial_rx
  import srx_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sen_ni,
  input  logic            sdata_i,
  input  logic            sclk_i,
  input  logic            tx_en_i,
  input  logic            sleep_ni,
  output logic [CODE_W-1:0] gain_code_o,
  output logic [DB_W-1:0]   gain_db_o,
  output logic            clamp_o,
  output logic            tx_on_o,
  output logic            idle_o,
  output logic            sleep_o
);
  // pin order: sleep_n, tx_en, sen_n, sclk, sdata
  localparam logic [4:0] PIN_RST = 5'b1_0_1_0_0;

  logic [4:0]        pins_s;
  logic [CODE_W-1:0] word;
  logic [CODE_W-1:0] code;

  srx_sync #(.W(5), .STAGES(2), .RST_VAL(PIN_RST)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sleep_ni, tx_en_i, sen_ni, sclk_i, sdata_i}),
    .q_o    (pins_s)
  );

  srx_shift #(.CODE_W(CODE_W)) i_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sen_n_s_i (pins_s[2]),
    .sclk_s_i  (pins_s[1]),
    .sdata_s_i (pins_s[0]),
    .word_o    (word)
  );

  srx_latch #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) i_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sen_n_s_i (pins_s[2]),
    .word_i    (word),
    .code_o    (code),
    .clamp_o   (clamp_o)
  );

  srx_mode i_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tx_en_s_i   (pins_s[3]),
    .sleep_n_s_i (pins_s[4]),
    .tx_on_o     (tx_on_o),
    .idle_o      (idle_o),
    .sleep_o     (sleep_o)
  );

  assign gain_code_o = code;
  assign gain_db_o   = DB_W'(code) * DB_W'(STEP_01M);

  // R7
  db_zero_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code == '0) |-> (gain_db_o == '0));
endmodule

// File: tb/test_gain_serial_rx.sv
module test_gain_serial_rx;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sen_ni = 1'b1, sdata_i = 1'b0, sclk_i = 1'b0;
  logic        tx_en_i = 1'b0, sleep_ni = 1'b1;
  logic [7:0]  gain_code_o;
  logic [19:0] gain_db_o;
  logic        clamp_o, tx_on_o, idle_o, sleep_o;

  int n_cmp = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  gain_serial_rx i_gain_serial_rx (
    .clk_i(clk), .rst_ni(rst_ni), .sen_ni(sen_ni), .sdata_i(sdata_i),
    .sclk_i(sclk_i), .tx_en_i(tx_en_i), .sleep_ni(sleep_ni),
    .gain_code_o(gain_code_o), .gain_db_o(gain_db_o), .clamp_o(clamp_o),
    .tx_on_o(tx_on_o), .idle_o(idle_o), .sleep_o(sleep_o)
  );

  function automatic int exp_code(input int w);
    return (w > 79) ? 79 : w;
  endfunction

  function automatic int exp_db(input int w);
    return exp_code(w) * 7526;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // shifts w MSB first; data is flipped between rise and fall of each bit
  task automatic shift_word(input logic [7:0] w);
    for (int b = 7; b >= 0; b--) begin
      sdata_i = w[b];  cyc(4);
      sclk_i  = 1'b1;  cyc(4);
      sdata_i = ~w[b]; cyc(4);
      sclk_i  = 1'b0;  cyc(4);
    end
  endtask

  task automatic check_gain(input string req, input int w);
    chk(req, int'(gain_code_o), exp_code(w));
    chk(req, int'(gain_db_o), exp_db(w));
    chk(req, int'(clamp_o), (w > 79) ? 1 : 0);
  endtask

  task automatic send(input logic [7:0] w);
    sen_ni = 1'b0; cyc(4);
    shift_word(w);
    sen_ni = 1'b1; cyc(4);
  endtask

  task automatic check_mode(input logic tx, input logic sl_n);
    int s, t, i;
    tx_en_i = tx; sleep_ni = sl_n;
    cyc(2);
    s = !sl_n ? 1 : 0;
    t = (sl_n && tx) ? 1 : 0;
    i = (sl_n && !tx) ? 1 : 0;
    chk("R8 sleep_o", int'(sleep_o), s);
    chk("R8 tx_on_o", int'(tx_on_o), t);
    chk("R8 idle_o",  int'(idle_o),  i);
    cyc(2);
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    if (!done) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    int seed;
    int prev;
    seed = $urandom(32'h5eed);
    cyc(3);
    rst_ni = 1'b1;
    cyc(4);
    // R1 reset state
    chk("R1 code",  int'(gain_code_o), 0);
    chk("R1 db",    int'(gain_db_o), 0);
    chk("R1 clamp", int'(clamp_o), 0);
    chk("R1 idle",  int'(idle_o), 1);
    chk("R1 tx",    int'(tx_on_o), 0);
    chk("R1 sleep", int'(sleep_o), 0);

    // R2 MSB-first, R5 data flip between edges, R9 latency
    sen_ni = 1'b0; cyc(4);
    shift_word(8'd37);
    chk("R3 held during load", int'(gain_code_o), 0);
    sen_ni = 1'b1;
    cyc(2);
    chk("R9 not yet at 2", int'(gain_code_o), 0);
    cyc(1);
    chk("R9 due at 3", int'(gain_code_o), 37);
    cyc(1);
    check_gain("R2 R5 R7 word 37", 37);

    // R6 boundaries
    send(8'd79);  check_gain("R6 code 79", 79);
    send(8'd80);  check_gain("R6 code 80 clamps", 80);
    send(8'd255); check_gain("R6 code 255 clamps", 255);
    send(8'd1);   check_gain("R2 R6 code 1 clears flag", 1);
    send(8'h40);  check_gain("R2 msb weight", 64);

    // R3 mid-load hold
    sen_ni = 1'b0; cyc(4);
    shift_word(8'd12);
    chk("R3 hold before commit", int'(gain_code_o), 64);
    sen_ni = 1'b1; cyc(4);
    check_gain("R3 commit 12", 12);

    // R4 edges with enable high are ignored
    for (int k = 0; k < 3; k++) begin
      sdata_i = 1'b1; cyc(4);
      sclk_i  = 1'b1; cyc(4);
      sclk_i  = 1'b0; cyc(4);
    end
    chk("R4 gain unchanged", int'(gain_code_o), 12);
    sen_ni = 1'b0; cyc(4);
    sen_ni = 1'b1; cyc(4);
    check_gain("R4 recommit keeps word", 12);

    // random words
    prev = 12;
    for (int n = 0; n < 24; n++) begin
      logic [7:0] w;
      w = 8'($urandom);
      if (n % 3 == 0) w = 8'($urandom_range(0, 79));
      send(w);
      check_gain("R2 R6 R7 random", int'(w));
      prev = int'(w);
    end

    // R8 modes
    check_mode(1'b1, 1'b1);
    check_mode(1'b0, 1'b1);
    check_mode(1'b1, 1'b0);
    check_mode(1'b0, 1'b0);
    check_mode(1'b1, 1'b1);
    chk("R8 gain unaffected by mode", int'(gain_code_o), exp_code(prev));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule